// File: doc/BRIEF.md
# Serial Register-Access Slave Engine

This block is a byte-oriented slave on a four-wire synchronous serial bus. It gives a bus master read and write access to a sixteen-entry, eight-bit register file within one chip-select frame. Every frame opens with a command byte. Bit 7 of that byte selects the direction and the low four bits carry the start address. A protected count byte follows. Its high nibble holds the number of registers minus one, and its low nibble holds the bitwise inverse of that number.

A write frame echoes each received byte back on the serial output one byte later, so the master can watch its own data for corruption. The write data is held in a staging buffer. It reaches the register file only when the frame closes cleanly.

A read frame returns the requested registers at consecutive addresses. During a read the master echoes each value back one byte late and the slave checks that echo. The slave then ends the read with a trailer: the last address, followed by a pass or fail control byte. While the control byte is being sent, the slave compares the input line against the output line bit by bit. On the first difference it inverts the rest of the control byte. The full register contents are presented in parallel for the logic that consumes them.

Top module: `sra_engine`

## Requirements
- R1: While `spi_csn` is high, `spi_miso` is 0 and the bit and byte position is cleared. Releasing chip select part way through a frame abandons that frame, and the next frame starts again at byte 0.
- R2: Bytes are sent MSB first. `spi_mosi` is sampled on the rising edge of `spi_sclk`, and `spi_miso` changes after the falling edge. In byte 0 of every frame, `spi_miso` sends 0x00. In the command byte, bit 7 = 1 selects a read, bit 7 = 0 selects a write, and bits 3:0 hold the start address A.
- R3: The count byte carries n in bits 7:4 and ~n in bits 3:0, and n+1 registers are transferred. n = 0 is a single-register access. A count byte whose low nibble is not ~n is a transmission error.
- R4: In a write frame, `spi_miso` in every byte k ≥ 1 repeats the byte received in byte k-1. In a read frame, bytes 1 and 2 repeat the command byte and the skip byte.
- R5: A read frame is: command (byte 0), one skip byte whose value is ignored (byte 1), count (byte 2). Bytes 3 to 3+n then return register (A+i) mod 16, for i = 0 to n.
- R6: In a read frame, byte 4+n returns {4'h0, (A+n) mod 16}. Byte 5+n returns 0xA6 if an error occurred, otherwise 0x59. An error is a bad count byte, or a master byte in slots 4 to 4+n that differs from the byte the slave sent in the slot before it.
- R7: While 0x59 is being sent, the first bit where `spi_mosi` differs from `spi_miso` at a rising edge inverts every later bit of that control byte. The bit where the difference occurred is not changed.
- R8: In a read frame, every byte after the control byte returns 0x00.
- R9: Write data is committed when chip select rises, and only if all of these hold: exactly n+1 complete data bytes were received, no partial byte is pending, and the count byte was valid. A short frame, an extra byte, trailing bits or a bad count byte leave all registers unchanged.
- R10: Both reads and writes increment the address modulo 16, so a burst wraps from register 15 to register 0.
- R11: `regs_o[8*i+7:8*i]` shows register i. All registers are 0 after a synchronous active-low reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the serial lines are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sclk | input | 1 | Serial clock (idle low) |
| spi_csn | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| regs_o | output | 128 | Register file contents, register i at bits 8*i+7:8*i |

## Verification
Several properties are checked on every clock. The output stays quiet and the bit position clears whenever chip select is high. The read-only and write-only protocol states are never entered for the wrong direction. The byte after the last-address slot is always one of the two control codes. The register file never changes outside a commit pulse.

Other behaviour depends on whole frames and can only be shown by the bench's scenarios. Examples are the exact echo bytes, the wrapped burst addresses, and which error source turns the trailer into 0xA6. The same holds for the bit at which a line mismatch inverts the control byte, and for whether a short, long, partial or badly counted write leaves the registers intact.

// File: rtl/sra_pkg.sv
// Shared definitions for the serial register-access engine.
package sra_pkg;
    typedef enum logic [2:0] {
        ST_CMD, ST_SKIP, ST_COUNT, ST_RDATA,
        ST_RADDR, ST_RCTRL, ST_WDATA, ST_TAIL
    } sra_state_e;

    localparam logic [7:0] CTRL_PASS = 8'h59;
    localparam logic [7:0] CTRL_FAIL = 8'hA6;
endpackage

// File: rtl/sra_shifter.sv
// Bit-level front end. It oversamples the serial clock with clk, shifts
// bytes in MSB first on the rising edges and shifts the reply out after
// the falling edges. A byte queued on the last rising edge of a byte is
// loaded on the falling edge that follows it.
// Assumes sclk, csn and mosi are synchronous to clk and that each sclk
// level lasts for at least one clk cycle.
module sra_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              csn_i,
    input  logic              mosi_i,
    input  logic [BYTE_W-1:0] load_byte_i,
    input  logic              invert_i,
    output logic              miso_o,
    output logic              rise_o,
    output logic              byte_stb_o,
    output logic [BYTE_W-1:0] rx_byte_o,
    output logic              aligned_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic              sclk_q;
    logic              fall;
    logic              load_pend;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;

    // Keep the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_i;
    end

    assign rise_o     = !csn_i && sclk_i && !sclk_q;
    assign fall       = !csn_i && !sclk_i && sclk_q;
    assign byte_stb_o = rise_o && (bit_cnt == CNT_W'(BYTE_W - 1));
    assign rx_byte_o  = {rx_sr[BYTE_W-2:0], mosi_i};
    assign aligned_o  = (bit_cnt == '0);
    assign miso_o     = tx_sr[BYTE_W-1];

    // Receive side: count the bits and shift mosi in.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (csn_i) begin
            bit_cnt <= '0;
            rx_sr   <= '0;
        end else if (rise_o) begin
            bit_cnt <= bit_cnt + CNT_W'(1);
            rx_sr   <= rx_byte_o;
        end
    end

    // Transmit side: load on the falling edge after each byte, shift otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_sr     <= '0;
            load_pend <= 1'b0;
        end else if (csn_i) begin
            tx_sr     <= '0;
            load_pend <= 1'b0;
        end else begin
            if (byte_stb_o) load_pend <= 1'b1;
            if (rise_o && invert_i) begin
                tx_sr <= ~tx_sr;
            end else if (fall) begin
                if (load_pend) begin
                    tx_sr     <= load_byte_i;
                    load_pend <= 1'b0;
                end else begin
                    tx_sr <= tx_sr << 1;
                end
            end
        end
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        csn_i |=> !miso_o);
    assert_position_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        csn_i |=> aligned_o);
endmodule

// File: rtl/sra_protocol.sv
// Byte-level protocol engine. It decodes the command and the protected
// count, schedules the reply byte for every slot (echo, register data,
// last address or control code), checks the master's echo during reads,
// drives the staging writes and raises a commit pulse at the close of a
// clean write frame.
// Assumes the strobes come from sra_shifter. A rising csn resets the frame.
module sra_protocol
    import sra_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csn_i,
    input  logic              mosi_i,
    input  logic              miso_i,
    input  logic              rise_i,
    input  logic              byte_stb_i,
    input  logic [DATA_W-1:0] rx_byte_i,
    input  logic              aligned_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] tx_byte_o,
    output logic              invert_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    output logic              st_we_o,
    output logic [ADDR_W-1:0] st_addr_o,
    output logic [DATA_W-1:0] st_data_o,
    output logic              commit_o,
    output logic              frame_end_o
);
    localparam int NIB_W   = DATA_W / 2;
    localparam int RD_FLAG = DATA_W - 1;

    sra_state_e        state;
    logic              is_read;
    logic [ADDR_W-1:0] ptr;
    logic [NIB_W-1:0]  remain;
    logic              err;
    logic              echo_armed;
    logic              wr_full;
    logic              wr_over;
    logic              ctrl_flipped;
    logic              csn_q;
    logic [DATA_W-1:0] sent_prev;

    logic [NIB_W-1:0]  cnt_field;
    logic              cnt_bad;
    logic              echo_bad;

    assign cnt_field   = rx_byte_i[DATA_W-1:NIB_W];
    assign cnt_bad     = rx_byte_i[NIB_W-1:0] != ~cnt_field;
    assign echo_bad    = rx_byte_i != sent_prev;
    assign rd_addr_o   = (state == ST_COUNT) ? ptr : ptr + ADDR_W'(1);
    assign st_we_o     = byte_stb_i && (state == ST_WDATA);
    assign st_addr_o   = ptr;
    assign st_data_o   = rx_byte_i;
    assign invert_o    = rise_i && (state == ST_RCTRL) && !ctrl_flipped &&
                         (tx_byte_o == CTRL_PASS) && (mosi_i != miso_i);
    assign frame_end_o = csn_i && !csn_q;
    assign commit_o    = frame_end_o && !is_read && wr_full && !wr_over &&
                         !err && aligned_i;

    // Frame state: step through the slots on each completed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csn_q        <= 1'b1;
            state        <= ST_CMD;
            is_read      <= 1'b0;
            ptr          <= '0;
            remain       <= '0;
            err          <= 1'b0;
            echo_armed   <= 1'b0;
            wr_full      <= 1'b0;
            wr_over      <= 1'b0;
            ctrl_flipped <= 1'b0;
            sent_prev    <= '0;
            tx_byte_o    <= '0;
        end else begin
            csn_q <= csn_i;
            if (csn_i) begin
                state        <= ST_CMD;
                is_read      <= 1'b0;
                ptr          <= '0;
                remain       <= '0;
                err          <= 1'b0;
                echo_armed   <= 1'b0;
                wr_full      <= 1'b0;
                wr_over      <= 1'b0;
                ctrl_flipped <= 1'b0;
                sent_prev    <= '0;
                tx_byte_o    <= '0;
            end else begin
                if (invert_o) ctrl_flipped <= 1'b1;
                if (byte_stb_i) begin
                    sent_prev <= tx_byte_o;
                    case (state)
                        ST_CMD: begin
                            is_read   <= rx_byte_i[RD_FLAG];
                            ptr       <= rx_byte_i[ADDR_W-1:0];
                            tx_byte_o <= rx_byte_i;
                            state     <= rx_byte_i[RD_FLAG] ? ST_SKIP : ST_COUNT;
                        end
                        ST_SKIP: begin
                            tx_byte_o <= rx_byte_i;
                            state     <= ST_COUNT;
                        end
                        ST_COUNT: begin
                            remain <= cnt_field;
                            if (cnt_bad) err <= 1'b1;
                            if (is_read) begin
                                tx_byte_o <= rd_data_i;
                                state     <= ST_RDATA;
                            end else begin
                                tx_byte_o <= rx_byte_i;
                                state     <= ST_WDATA;
                            end
                        end
                        ST_RDATA: begin
                            if (echo_armed && echo_bad) err <= 1'b1;
                            echo_armed <= 1'b1;
                            if (remain == '0) begin
                                tx_byte_o <= DATA_W'(ptr);
                                state     <= ST_RADDR;
                            end else begin
                                ptr       <= ptr + ADDR_W'(1);
                                remain    <= remain - NIB_W'(1);
                                tx_byte_o <= rd_data_i;
                            end
                        end
                        ST_RADDR: begin
                            if (echo_bad) err <= 1'b1;
                            tx_byte_o <= (err || echo_bad) ? CTRL_FAIL : CTRL_PASS;
                            state     <= ST_RCTRL;
                        end
                        ST_RCTRL: begin
                            tx_byte_o <= '0;
                            state     <= ST_TAIL;
                        end
                        ST_WDATA: begin
                            tx_byte_o <= rx_byte_i;
                            ptr       <= ptr + ADDR_W'(1);
                            if (remain == '0) begin
                                wr_full <= 1'b1;
                                state   <= ST_TAIL;
                            end else begin
                                remain <= remain - NIB_W'(1);
                            end
                        end
                        ST_TAIL: begin
                            tx_byte_o <= is_read ? '0 : rx_byte_i;
                            if (!is_read) wr_over <= 1'b1;
                        end
                        default: state <= ST_CMD;
                    endcase
                end
            end
        end
    end

    assert_read_states_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state inside {ST_SKIP, ST_RDATA, ST_RADDR, ST_RCTRL}) |-> is_read);
    assert_write_states_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA) |-> !is_read);
    assert_trailer_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_stb_i && !csn_i && state == ST_RADDR) |=>
        (tx_byte_o == CTRL_PASS || tx_byte_o == CTRL_FAIL));
    assert_flip_on_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RCTRL && ctrl_flipped) |-> (tx_byte_o == CTRL_PASS));
endmodule

// File: rtl/sra_regfile.sv
// Register file with a staging buffer. Write-frame bytes land in the stage
// and set a per-entry mark. A commit pulse copies the marked entries into
// the live registers. The end of every frame clears the marks.
// Assumes staging writes and frame end never coincide.
module sra_regfile #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [DATA_W-1:0]             rd_data_o,
    input  logic                          st_we_i,
    input  logic [ADDR_W-1:0]             st_addr_i,
    input  logic [DATA_W-1:0]             st_data_i,
    input  logic                          commit_i,
    input  logic                          clear_i,
    output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] regs  [DEPTH];
    logic [DATA_W-1:0] stage [DEPTH];
    logic [DEPTH-1:0]  marked;

    assign rd_data_o = regs[rd_addr_i];

    for (genvar i = 0; i < DEPTH; i++) begin : g_entry
        // Live register: updated only by a commit of a marked entry.
        always_ff @(posedge clk) begin
            if (!rst_n)                      regs[i] <= '0;
            else if (commit_i && marked[i])  regs[i] <= stage[i];
        end

        // Stage entry and its mark: filled by frame data, cleared at frame end.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                stage[i]  <= '0;
                marked[i] <= 1'b0;
            end else if (st_we_i && st_addr_i == ADDR_W'(i)) begin
                stage[i]  <= st_data_i;
                marked[i] <= 1'b1;
            end else if (clear_i) begin
                marked[i] <= 1'b0;
            end
        end

        assign regs_o[i*DATA_W +: DATA_W] = regs[i];
    end

    assert_hold_without_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(regs_o));
endmodule

// File: rtl/sra_engine.sv
// Top of the serial register-access slave. It connects the bit shifter,
// the protocol engine and the staged register file.
// Assumes all serial inputs are synchronous to clk and that a clk period
// is shorter than half an sclk period.
module sra_engine #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          spi_sclk,
    input  logic                          spi_csn,
    input  logic                          spi_mosi,
    output logic                          spi_miso,
    output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o
);
    logic              rise;
    logic              byte_stb;
    logic              aligned;
    logic              invert;
    logic              st_we;
    logic              commit;
    logic              frame_end;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] tx_byte;
    logic [DATA_W-1:0] rd_data;
    logic [DATA_W-1:0] st_data;
    logic [ADDR_W-1:0] rd_addr;
    logic [ADDR_W-1:0] st_addr;

    sra_shifter #(.BYTE_W(DATA_W)) shifter_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(spi_sclk), .csn_i(spi_csn),
        .mosi_i(spi_mosi), .load_byte_i(tx_byte), .invert_i(invert),
        .miso_o(spi_miso), .rise_o(rise), .byte_stb_o(byte_stb),
        .rx_byte_o(rx_byte), .aligned_o(aligned)
    );

    sra_protocol #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) protocol_i (
        .clk(clk), .rst_n(rst_n), .csn_i(spi_csn), .mosi_i(spi_mosi),
        .miso_i(spi_miso), .rise_i(rise), .byte_stb_i(byte_stb),
        .rx_byte_i(rx_byte), .aligned_i(aligned), .rd_data_i(rd_data),
        .tx_byte_o(tx_byte), .invert_o(invert), .rd_addr_o(rd_addr),
        .st_we_o(st_we), .st_addr_o(st_addr), .st_data_o(st_data),
        .commit_o(commit), .frame_end_o(frame_end)
    );

    sra_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) regfile_i (
        .clk(clk), .rst_n(rst_n), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .st_we_i(st_we), .st_addr_i(st_addr), .st_data_i(st_data),
        .commit_i(commit), .clear_i(frame_end), .regs_o(regs_o)
    );
endmodule

// File: tb/sra_engine_tb_top.sv
// Bench: a behavioural master and register model. Every serial bit of the
// reply is compared with the model, and the register file after every frame.
module sra_engine_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0;
    logic         csn = 1'b1;
    logic         mosi = 1'b0;
    logic         miso;
    logic [127:0] regs;
    int           n_checks = 0;
    int           n_fail = 0;
    bit           done = 1'b0;
    logic [7:0]   mregs [16];

    always #10 clk = ~clk;

    sra_engine dut_i (
        .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_csn(csn),
        .spi_mosi(mosi), .spi_miso(miso), .regs_o(regs)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 16; i++)
            check(regs[i*8 +: 8] == mregs[i], req, regs[i*8 +: 8], mregs[i]);
    endtask

    // Drive one frame; compare miso on every bit against the expected bytes.
    task automatic run_frame(input logic [7:0] tx[$], input logic [7:0] ex[$],
                             input string tg[$], input int ctrl_slot,
                             input int extra_bits);
        logic flipped = 1'b0;
        logic eb;
        @(negedge clk) csn = 1'b0;
        repeat (2) @(negedge clk);
        for (int s = 0; s < tx.size(); s++) begin
            for (int b = 7; b >= 0; b--) begin
                @(negedge clk);
                mosi = tx[s][b];
                eb = ex[s][b] ^ ((s == ctrl_slot) && flipped);
                check(miso == eb, tg[s], int'(miso), int'(eb));
                repeat (2) @(negedge clk);
                sclk = 1'b1;
                if (s == ctrl_slot && !flipped && ex[s] == 8'h59 && mosi != eb)
                    flipped = 1'b1;
                repeat (2) @(negedge clk);
                sclk = 1'b0;
            end
        end
        for (int b = 0; b < extra_bits; b++) begin
            @(negedge clk);
            mosi = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b1;
            repeat (2) @(negedge clk);
            sclk = 1'b0;
        end
        repeat (3) @(negedge clk);
        csn = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic do_read(input int a, input int n, input bit bad_cnt,
                           input bit echo_err, input bit ctrl_bad);
        logic [7:0] tx[$];
        logic [7:0] ex[$];
        string      tg[$];
        logic [7:0] cmd  = 8'h80 | 8'(a);
        logic [3:0] nn   = 4'(n);
        logic [7:0] cnt  = {nn, ~nn ^ {3'b000, bad_cnt}};
        logic [7:0] ctrl = (bad_cnt || echo_err) ? 8'hA6 : 8'h59;
        tx.push_back(cmd);   ex.push_back(8'h00); tg.push_back("R2");
        tx.push_back(8'h3D); ex.push_back(cmd);   tg.push_back("R4");
        tx.push_back(cnt);   ex.push_back(8'h3D); tg.push_back("R4");
        for (int i = 0; i <= n; i++) begin
            tx.push_back(i == 0 ? 8'h00 : mregs[(a + i - 1) % 16]);
            ex.push_back(mregs[(a + i) % 16]);
            tg.push_back((a + i) >= 16 ? "R10" : (n == 0 ? "R3" : "R5"));
        end
        tx.push_back(mregs[(a + n) % 16]);
        ex.push_back(8'((a + n) % 16)); tg.push_back("R6");
        tx.push_back(ctrl ^ (ctrl_bad ? 8'h02 : 8'h00));
        ex.push_back(ctrl); tg.push_back(ctrl_bad ? "R7" : "R6");
        tx.push_back(8'h00); ex.push_back(8'h00); tg.push_back("R8");
        if (echo_err) tx[4] = tx[4] ^ 8'h10;
        run_frame(tx, ex, tg, 5 + n, 0);
        check_regs("R5");
    endtask

    // mode: 0 clean, 1 short, 2 extra byte, 3 bad count, 4 trailing bits
    task automatic do_write(input int a, input int n, input int seed, input int mode);
        logic [7:0] tx[$];
        logic [7:0] ex[$];
        string      tg[$];
        logic [7:0] data[$];
        logic [3:0] nn = 4'(n);
        for (int i = 0; i <= n; i++) data.push_back(8'(seed + i * 37));
        tx.push_back(8'(a));
        tx.push_back({nn, ~nn ^ (mode == 3 ? 4'h1 : 4'h0)});
        for (int i = 0; i <= n; i++)
            if (!(mode == 1 && i == n)) tx.push_back(data[i]);
        if (mode == 2) tx.push_back(8'hEE);
        ex.push_back(8'h00); tg.push_back("R2");
        for (int k = 1; k < tx.size(); k++) begin
            ex.push_back(tx[k-1]);
            tg.push_back("R4");
        end
        run_frame(tx, ex, tg, -1, mode == 4 ? 4 : 0);
        if (mode == 0)
            for (int i = 0; i <= n; i++) mregs[(a + i) % 16] = data[i];
        check_regs(mode == 0 ? ((a + n) >= 16 ? "R10" : "R9") : "R9");
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mregs[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(miso == 1'b0, "R1", int'(miso), 0);
        check_regs("R11");
        do_write(3, 0, 8'h3C, 0);
        do_write(14, 3, 8'h11, 0);
        do_read(3, 0, 1'b0, 1'b0, 1'b0);
        do_read(14, 3, 1'b0, 1'b0, 1'b0);
        do_read(14, 3, 1'b1, 1'b0, 1'b0);
        do_read(2, 2, 1'b0, 1'b1, 1'b0);
        do_read(3, 0, 1'b0, 1'b0, 1'b1);
        do_read(7, 1, 1'b0, 1'b0, 1'b1);
        do_write(5, 1, 8'h71, 1);
        check(miso == 1'b0, "R1", int'(miso), 0);
        do_write(5, 1, 8'h72, 2);
        do_write(5, 1, 8'h73, 3);
        do_write(5, 1, 8'h74, 4);
        do_read(5, 1, 1'b0, 1'b0, 1'b0);
        do_write(0, 15, 8'h01, 0);
        do_read(9, 15, 1'b0, 1'b0, 1'b0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule